// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a compact 32-bit processor for a small load/store instruction subset. Each instruction passes through a sequence of one-clock phases that a finite-state controller steps through. Simple instructions use fewer phases than complex ones, so the clock period is set by the slowest phase rather than by the slowest instruction. Each instruction class therefore retires after its own number of cycles. A single ALU is shared by the program-counter arithmetic and the operand arithmetic. A single memory port is shared by instruction fetch and data access. Latches between phases carry the partial results: the instruction word, the loaded data word, the two register operands and the ALU result.

The supported instructions are register-register add, subtract, and, or and signed set-less-than, plus word load, word store, branch-if-equal and an absolute jump. Code and data sit in one word-addressed memory inside the core. Memory is written on the clock edge and read without a clock. While reset is held, an external load port owns that memory, so a host can place a program and data there before releasing reset and can read the results afterwards. A one-cycle retire pulse and the program counter come out as registered outputs, so cycles per instruction can be measured from outside.

Top module: `mc_core`

## Requirements
- R1: Reset is synchronous and active high. On a clock edge with reset high, the program counter becomes 0, the controller enters its fetch phase and the retire output goes low. While reset is high, the load port (write enable, word address, write data, read data) has sole access to the memory.
- R2: Cycle counts per instruction are fixed. A load takes 5 cycles. A store takes 4 cycles. A register-register instruction takes 4 cycles. A branch-if-equal takes 3 cycles, whether or not it is taken. A jump takes 3 cycles. `retire` is high for exactly one cycle, the cycle after the final phase, and that cycle is the fetch of the next instruction.
- R3: The fetch phase reads the memory word at the program counter into the instruction latch and writes PC+4 into the program counter in that same cycle. No phase except fetch and a control transfer changes the program counter.
- R4: An instruction with opcode field [31:26] = 0x00 is register-register: rs=[25:21], rt=[20:16], rd=[15:11], funct=[5:0]. The funct values are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (rd = 1 if rs < rt as signed, else 0). The result goes to rd.
- R5: Load (opcode 0x23) and store (opcode 0x2B) use byte address rs + sign-extended imm[15:0]. Bits [7:2] of that address select the memory word. A load writes the word to rt. A store writes rt to memory, and it does so only in its final phase.
- R6: Branch-if-equal (opcode 0x04) compares rs and rt by subtraction in the ALU. If they are equal, the PC becomes PC+4 + (sign-extended imm << 2), a negative offset included. Otherwise the PC stays at PC+4.
- R7: Jump (opcode 0x02) sets the PC to {(PC+4)[31:28], index[25:0], 2'b00}. Any instructions between the jump and its target do not execute.
- R8: Register 0 always reads 0. A write whose destination is register 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; while high, the load port owns the memory |
| ld_we | input | 1 | Load-port write enable (acts only while rst is high) |
| ld_addr | input | 6 | Load-port word address |
| ld_wdata | input | 32 | Load-port write data |
| ld_rdata | output | 32 | Memory word at the current memory address (ld_addr while rst is high) |
| pc | output | 32 | Program counter register |
| retire | output | 1 | One-cycle pulse after each instruction's final phase |

## Verification
The bound checker watches several rules on every cycle. Reset forces the PC to zero. The PC advances by exactly four in each fetch. The PC holds steady through decode. A retire pulse never lasts two cycles and always lines up with a fetch. Register 0 always reads zero. Cycle counts per instruction class, the ALU results for each funct code, the computed branch and jump targets, and the skipped instructions after a taken branch or jump depend on the program, so only the bench's program run and its memory readback show them. The program's store results are read back through the load port afterwards.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_ALUWB, ST_MEMADR,
    ST_MEMRD, ST_MEMWB, ST_MEMWR, ST_BRANCH, ST_JUMP
  } state_t;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_t;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  // operand select codes for the shared ALU
  localparam logic [1:0] BSEL_REG   = 2'd0;
  localparam logic [1:0] BSEL_FOUR  = 2'd1;
  localparam logic [1:0] BSEL_SEXT  = 2'd2;
  localparam logic [1:0] BSEL_SEXT4 = 2'd3;

  localparam logic [1:0] PCSRC_ALU  = 2'd0;
  localparam logic [1:0] PCSRC_LAT  = 2'd1;
  localparam logic [1:0] PCSRC_JMP  = 2'd2;

  typedef struct packed {
    logic    pc_we;
    logic    pc_cond;
    logic [1:0] pc_src;
    logic    iord;
    logic    mem_we;
    logic    ir_we;
    logic    rf_we;
    logic    dst_rd;
    logic    from_mem;
    logic    a_reg;
    logic [1:0] b_sel;
    alu_op_t alu_op;
  } ctl_t;

  function automatic alu_op_t funct_to_op(input logic [5:0] f);
    case (f)
      6'h22:   return ALU_SUB;
      6'h24:   return ALU_AND;
      6'h25:   return ALU_OR;
      6'h2A:   return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction
endpackage

// File: rtl/mc_alu.sv
module mc_alu import mc_pkg::*; #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_t       op,
  output logic [DW-1:0] y,
  output logic          zero
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int DW   = 32,
  parameter int REGS = 32,
  localparam int RAW = $clog2(REGS)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] ra1,
  input  logic [RAW-1:0] ra2,
  output logic [DW-1:0]  rd1,
  output logic [DW-1:0]  rd2
);
  logic [DW-1:0] regs [REGS];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int MAW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [MAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[addr] <= wdata;
  end

  assign rdata = ram[addr];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl import mc_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output state_t     state,
  output ctl_t       ctl,
  output logic       retire
);
  state_t nxt;
  logic   fin;

  always_comb begin
    ctl    = '0;
    ctl.alu_op = ALU_ADD;
    nxt    = ST_FETCH;
    fin    = 1'b0;
    case (state)
      ST_FETCH: begin
        ctl.ir_we = 1'b1; ctl.pc_we = 1'b1;
        ctl.b_sel = BSEL_FOUR; ctl.pc_src = PCSRC_ALU;
        nxt = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.b_sel = BSEL_SEXT4;
        case (opcode)
          OP_RTYPE:     nxt = ST_EXEC;
          OP_LW, OP_SW: nxt = ST_MEMADR;
          OP_BEQ:       nxt = ST_BRANCH;
          OP_J:         nxt = ST_JUMP;
          default:      fin = 1'b1;
        endcase
      end
      ST_EXEC: begin
        ctl.a_reg = 1'b1; ctl.b_sel = BSEL_REG;
        ctl.alu_op = funct_to_op(funct);
        nxt = ST_ALUWB;
      end
      ST_ALUWB: begin
        ctl.rf_we = 1'b1; ctl.dst_rd = 1'b1; fin = 1'b1;
      end
      ST_MEMADR: begin
        ctl.a_reg = 1'b1; ctl.b_sel = BSEL_SEXT;
        nxt = (opcode == OP_LW) ? ST_MEMRD : ST_MEMWR;
      end
      ST_MEMRD: begin
        ctl.iord = 1'b1; nxt = ST_MEMWB;
      end
      ST_MEMWB: begin
        ctl.rf_we = 1'b1; ctl.from_mem = 1'b1; fin = 1'b1;
      end
      ST_MEMWR: begin
        ctl.iord = 1'b1; ctl.mem_we = 1'b1; fin = 1'b1;
      end
      ST_BRANCH: begin
        ctl.a_reg = 1'b1; ctl.b_sel = BSEL_REG; ctl.alu_op = ALU_SUB;
        ctl.pc_cond = 1'b1; ctl.pc_src = PCSRC_LAT; fin = 1'b1;
      end
      ST_JUMP: begin
        ctl.pc_we = 1'b1; ctl.pc_src = PCSRC_JMP; fin = 1'b1;
      end
      default: nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FETCH;
      retire <= 1'b0;
    end else begin
      state  <= nxt;
      retire <= fin;
    end
  end
endmodule

// File: rtl/mc_core.sv
module mc_core import mc_pkg::*; #(
  parameter int DW        = 32,
  parameter int MEM_WORDS = 64,
  parameter int REGS      = 32,
  localparam int MAW      = $clog2(MEM_WORDS),
  localparam int RAW      = $clog2(REGS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_we,
  input  logic [MAW-1:0] ld_addr,
  input  logic [DW-1:0]  ld_wdata,
  output logic [DW-1:0]  ld_rdata,
  output logic [DW-1:0]  pc,
  output logic           retire
);
  state_t        state;
  ctl_t          ctl;
  logic [DW-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_q;
  logic [DW-1:0] rf_rd1, rf_rd2, alu_a, alu_b, alu_y, sext, mem_rdata, byte_addr;
  logic          alu_zero;
  logic [MAW-1:0] mem_addr;
  logic [RAW-1:0] rf_waddr;

  mc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(ir_q[31:26]), .funct(ir_q[5:0]),
    .state(state), .ctl(ctl), .retire(retire)
  );

  // instruction fields and immediate
  assign sext     = {{(DW-16){ir_q[15]}}, ir_q[15:0]};
  assign rf_waddr = ctl.dst_rd ? ir_q[15:11] : ir_q[20:16];

  mc_regfile #(.DW(DW), .REGS(REGS)) u_rf (
    .clk(clk), .we(ctl.rf_we && !rst), .waddr(rf_waddr),
    .wdata(ctl.from_mem ? mdr_q : alu_q),
    .ra1(ir_q[25:21]), .ra2(ir_q[20:16]), .rd1(rf_rd1), .rd2(rf_rd2)
  );

  // shared ALU operand selection
  assign alu_a = ctl.a_reg ? a_q : pc_q;
  always_comb begin
    case (ctl.b_sel)
      BSEL_FOUR:  alu_b = DW'(4);
      BSEL_SEXT:  alu_b = sext;
      BSEL_SEXT4: alu_b = sext << 2;
      default:    alu_b = b_q;
    endcase
  end

  mc_alu #(.DW(DW)) u_alu (
    .a(alu_a), .b(alu_b), .op(ctl.alu_op), .y(alu_y), .zero(alu_zero)
  );

  // one memory port: load port while in reset, fetch or data otherwise
  assign byte_addr = ctl.iord ? alu_q : pc_q;
  assign mem_addr  = rst ? ld_addr : byte_addr[MAW+1:2];

  mc_mem #(.DW(DW), .DEPTH(MEM_WORDS)) u_mem (
    .clk(clk), .we(rst ? ld_we : ctl.mem_we), .addr(mem_addr),
    .wdata(rst ? ld_wdata : b_q), .rdata(mem_rdata)
  );
  assign ld_rdata = mem_rdata;

  // phase latches and program counter
  always_ff @(posedge clk) begin
    mdr_q <= mem_rdata;
    a_q   <= rf_rd1;
    b_q   <= rf_rd2;
    alu_q <= alu_y;
    if (ctl.ir_we) ir_q <= mem_rdata;
    if (rst) begin
      pc_q <= '0;
    end else if (ctl.pc_we || (ctl.pc_cond && alu_zero)) begin
      case (ctl.pc_src)
        PCSRC_LAT: pc_q <= alu_q;
        PCSRC_JMP: pc_q <= {pc_q[DW-1:28], ir_q[25:0], 2'b00};
        default:   pc_q <= alu_y;
      endcase
    end
  end
  assign pc = pc_q;

  logic unused_bits;
  assign unused_bits = ^{byte_addr[DW-1:MAW+2], byte_addr[1:0], ir_q[10:6]};
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk import mc_pkg::*; #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          retire,
  input logic [DW-1:0] pc,
  input state_t        state,
  input logic [4:0]    rs_field,
  input logic [DW-1:0] rs_data
);
  // R1: reset clears the program counter and keeps retire low
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (pc == '0 && !retire));

  // R2: retire is a single-cycle pulse
  a_r2_retire_single: assert property (@(posedge clk) disable iff (rst) retire |=> !retire);

  // R2: the retire cycle is the next instruction's fetch
  a_r2_retire_at_fetch: assert property (@(posedge clk) disable iff (rst) retire |-> state == ST_FETCH);

  // R3: each fetch advances the program counter by four
  a_r3_fetch_step: assert property (@(posedge clk) disable iff (rst)
    state == ST_FETCH |=> pc == $past(pc) + DW'(4));

  // R3: decode never moves the program counter
  a_r3_decode_hold: assert property (@(posedge clk) disable iff (rst)
    state == ST_DECODE |=> $stable(pc));

  // R8: register 0 reads as zero
  a_r8_zero_reg: assert property (@(posedge clk) disable iff (rst)
    rs_field == 5'd0 |-> rs_data == '0);
endmodule

bind mc_core mc_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .retire(retire), .pc(pc_q), .state(state),
  .rs_field(ir_q[25:21]), .rs_data(rf_rd1)
);

// File: tb/tb_mc_core.sv
module tb_mc_core;
  localparam int DW = 32;
  localparam int MW = 64;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_wdata = '0;
  logic [DW-1:0] ld_rdata, pc;
  logic          retire;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mc_core dut (.clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr),
               .ld_wdata(ld_wdata), .ld_rdata(ld_rdata), .pc(pc), .retire(retire));

  function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] prog_word(input int i);
    case (i)
      0:  return enc_i(6'h23, 0, 1, 16'd192);
      1:  return enc_i(6'h23, 0, 2, 16'd196);
      2:  return enc_r(1, 2, 3, 6'h20);
      3:  return enc_r(1, 2, 4, 6'h22);
      4:  return enc_r(1, 2, 5, 6'h24);
      5:  return enc_r(1, 2, 6, 6'h25);
      6:  return enc_r(2, 1, 7, 6'h2A);
      7:  return enc_r(1, 2, 8, 6'h2A);
      8:  return enc_r(1, 1, 0, 6'h20);
      9:  return enc_i(6'h2B, 0, 3, 16'd200);
      10: return enc_i(6'h2B, 0, 4, 16'd204);
      11: return enc_i(6'h2B, 0, 5, 16'd208);
      12: return enc_i(6'h2B, 0, 6, 16'd212);
      13: return enc_i(6'h2B, 0, 7, 16'd216);
      14: return enc_i(6'h2B, 0, 8, 16'd220);
      15: return enc_i(6'h2B, 0, 0, 16'd224);
      16: return enc_i(6'h04, 1, 2, 16'd5);
      17: return enc_i(6'h04, 1, 1, 16'd1);
      18: return enc_i(6'h2B, 0, 1, 16'd228);
      19: return {6'h02, 26'd21};
      20: return enc_i(6'h2B, 0, 1, 16'd232);
      21: return enc_i(6'h2B, 0, 1, 16'd236);
      22: return enc_i(6'h04, 0, 0, 16'hFFFF);
      48: return 32'd7;
      49: return 32'hFFFF_FFFD;
      56: return 32'h0000_DEAD;
      57: return 32'h0000_1111;
      58: return 32'h0000_2222;
      default: return 32'd0;
    endcase
  endfunction

  // per retire: {expected cycles, expected pc afterwards}
  localparam int NV = 22;
  localparam logic [35:0] VEC [NV] = '{
    {4'd5, 32'd4},  {4'd5, 32'd8},
    {4'd4, 32'd12}, {4'd4, 32'd16}, {4'd4, 32'd20}, {4'd4, 32'd24},
    {4'd4, 32'd28}, {4'd4, 32'd32}, {4'd4, 32'd36},
    {4'd4, 32'd40}, {4'd4, 32'd44}, {4'd4, 32'd48}, {4'd4, 32'd52},
    {4'd4, 32'd56}, {4'd4, 32'd60}, {4'd4, 32'd64},
    {4'd3, 32'd68}, {4'd3, 32'd76}, {4'd3, 32'd84}, {4'd4, 32'd88},
    {4'd3, 32'd88}, {4'd3, 32'd88}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic peek(input int w, input logic [31:0] exp, input string tag);
    ld_addr = AW'(w);
    #1;
    chk(tag, ld_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // preload memory through the load port while in reset
    for (int i = 0; i < MW; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = AW'(i); ld_wdata = prog_word(i);
    end
    @(negedge clk);
    ld_we = 1'b0;
    chk("R1 reset pc", pc, 32'd0);
    chk("R1 reset retire", {31'd0, retire}, 32'd0);
    rst = 1'b0;

    // walk the table: cycles per instruction and pc after retire
    for (int v = 0; v < NV; v++) begin
      int n;
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!retire && n < 20);
      chk($sformatf("R2 cycles of retire %0d", v), 32'(n), 32'(VEC[v][35:32]));
      chk($sformatf("R3/R6/R7 pc after retire %0d", v), pc, VEC[v][31:0]);
      @(negedge clk);
      chk("R2 retire one cycle", {31'd0, retire}, 32'd0);
      n = 1;
      while (!retire && n < 20) begin
        @(negedge clk);
        n++;
        if (retire) break;
      end
      // fold the second wait back: re-sync by checking retire cadence
      if (v + 1 < NV) begin
        chk($sformatf("R2 cycles of retire %0d", v + 1), 32'(n), 32'(VEC[v+1][35:32]));
        chk($sformatf("R3/R6/R7 pc after retire %0d", v + 1), pc, VEC[v+1][31:0]);
        v++;
      end
    end

    // mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset pc", pc, 32'd0);
    chk("R1 mid-run reset retire", {31'd0, retire}, 32'd0);

    // results through the load port
    peek(50, 32'd4,          "R4 add");
    peek(51, 32'd10,         "R4 sub");
    peek(52, 32'd5,          "R4 and");
    peek(53, 32'hFFFF_FFFF,  "R4 or");
    peek(54, 32'd1,          "R4 slt true");
    peek(55, 32'd0,          "R4 slt false");
    peek(56, 32'd0,          "R8 reg0 write ignored");
    peek(57, 32'h0000_1111,  "R6 taken branch skips");
    peek(58, 32'h0000_2222,  "R7 jump skips");
    peek(59, 32'd7,          "R5/R7 load value stored at jump target");
    peek(48, 32'd7,          "R5 data word kept");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule